// File: doc/BRIEF.md
# Shared Radix-2 Divide and Square-Root Unit

This block is an iterative arithmetic unit for single-precision significands. Each operand arrives as a 24-bit significand with the hidden leading one already in place, so its value lies in [2^23, 2^24). A single start strobe launches either a division of operand A by operand B or a square root of operand A, chosen by an operation-select input that is sampled together with the operands. One signed result digit from {-1, 0, +1} is retired on every clock edge. Division and square root share one datapath, and the digits are written into a plain binary result without any carry-propagating conversion at the end.

The partial remainder is kept as two carry-save vectors. Each digit is chosen from a short estimate formed from the top few bits of the doubled remainder: a non-negative estimate selects +1, an estimate of exactly minus one half selects 0, and anything lower selects -1. For division the value added back is the divisor. For square root it is the partial root developed so far, adjusted by the position of the current digit. Two registers hold the running result and the result minus one unit in the last place, and both are updated on every digit. After the last digit the remainder is resolved once. If it is negative, the smaller of the two registers becomes the result, which completes the decrement-by-one correction.

The controller has five states. IDLE waits for start. ITER retires 25 digits. SIGN resolves the remainder sign. CORR picks the corrected result. DONE raises the completion pulse. The transitions are IDLE→ITER on an accepted start, ITER→ITER while digits remain, ITER→SIGN after the 25th digit, SIGN→CORR, CORR→DONE and DONE→IDLE, each of the last three taken unconditionally.

Top module: `dsq_unit`

## Requirements
- R1: While reset is asserted and after it is released, busy, done and the result are all zero until the first operation completes.
- R2: A start seen in IDLE is accepted: busy is high from the next cycle up to and including the done cycle, and it is low again in the cycle after done.
- R3: If start is high in cycle 1, done is high in cycle 29 and only in that cycle. Done never lasts more than one cycle.
- R4: With select low (divide), the 25-bit result equals floor(A·2^24 / B). Bit 24 has weight 1, so a result at or above 2^24 means A ≥ B.
- R5: With select high (square root), the 25-bit result equals floor(sqrt(A·2^26)). Bit 24 has weight 1.
- R6: The operation select and both operands are captured only in the cycle a start is accepted. Values on those inputs at other times have no effect on the result.
- R7: A start pulse while busy is ignored. It changes neither the pending result nor its completion time, and it produces no extra done.
- R8: The result stays stable from one done cycle until the next done cycle, including while a later operation is running.
- R9: Across extreme operand ratios (smallest and largest quotients, smallest and largest radicands), the redundant remainder stays inside [-2, 2) after every step and the result is exact.
- R10: Cases whose true result is exactly representable (zero final remainder) are returned without a decrement, and inexact cases that end with a negative remainder are returned decremented by one unit in the last place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, honoured only when idle |
| op_sqrt_i | input | 1 | Operation select: 0 divide, 1 square root |
| opa_i | input | 24 | Significand A (dividend or radicand), hidden one included |
| opb_i | input | 24 | Significand B (divisor), hidden one included |
| busy_o | output | 1 | High from the cycle after an accepted start through the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| res_o | output | 25 | Conventional binary result, bit 24 has weight 1 |

## Verification
The embedded properties check, on every cycle, that the remainder estimate keeps the carry-save remainder inside its bound and that the two conversion registers always differ by exactly one unit at the current digit position. They also check that done is a single pulse at the fixed latency, that the captured operands and select do not move while busy, and that the result does not change outside the correction step. Only the bench scenarios can show that the numbers are right: exact quotients and roots for operand extremes, exact and inexact cases that exercise the final correction, and a start issued mid-operation with different operands that leaves the pending result untouched.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ITER,
        ST_SIGN,
        ST_CORR,
        ST_DONE
    } dsq_state_e;

    // signed result digit: +1, 0, -1 (two's complement style code)
    typedef enum logic [1:0] {
        DG_ZERO = 2'b00,
        DG_POS  = 2'b01,
        DG_NEG  = 2'b11
    } dsq_digit_e;

    typedef enum logic {
        OP_DIV  = 1'b0,
        OP_SQRT = 1'b1
    } dsq_op_e;

endpackage

// File: rtl/dsq_select.sv
module dsq_select
    import dsq_pkg::*;
#(
    parameter int EW = 5
) (
    input  logic [EW-1:0] s_top_i,
    input  logic [EW-1:0] c_top_i,
    output dsq_digit_e    dig_o
);

    // estimate of the doubled remainder, LSB weight one half
    logic [EW-1:0] est;

    always_comb begin
        est = s_top_i + c_top_i;
        if (!est[EW-1]) begin
            dig_o = DG_POS;
        end else if (&est) begin
            dig_o = DG_ZERO;
        end else begin
            dig_o = DG_NEG;
        end
    end

endmodule

// File: rtl/dsq_recur.sv
module dsq_recur
    import dsq_pkg::*;
#(
    parameter int WW = 30,
    parameter int FB = 26,
    parameter int QW = 26,
    parameter int CW = 5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic          step_i,
    input  dsq_op_e       op_i,
    input  logic [WW-1:0] init_i,
    input  logic [WW-1:0] dvs_i,
    input  logic [QW-1:0] q_i,
    input  logic [QW-1:0] qm_i,
    input  logic [CW-1:0] idx_i,
    output dsq_digit_e    dig_o,
    output logic          neg_o
);

    localparam int EW = 5;
    localparam logic [CW-1:0] ETOP = CW'(FB - 2);
    localparam logic [WW-1:0] ONE = {{(WW-1){1'b0}}, 1'b1};
    localparam logic signed [WW-1:0] LIM = $signed(ONE << (FB + 1));

    logic [WW-1:0] ws_q, wc_q;
    logic [WW-1:0] sh_s, sh_c;
    logic [WW-1:0] q_w, qm_w, ebit, addend, nsum, ncar, rem_w;
    logic [WW-2:0] maj;
    logic          cin;

    assign sh_s = {ws_q[WW-2:0], 1'b0};
    assign sh_c = {wc_q[WW-2:0], 1'b0};

    dsq_select #(.EW(EW)) u_sel (
        .s_top_i (sh_s[WW-1:WW-EW]),
        .c_top_i (sh_c[WW-1:WW-EW]),
        .dig_o   (dig_o)
    );

    // partial root in remainder format, and the digit-position bit
    assign q_w  = {{(WW-QW){1'b0}}, q_i} << 1;
    assign qm_w = {{(WW-QW){1'b0}}, qm_i} << 1;
    assign ebit = ONE << (ETOP - idx_i);

    always_comb begin
        addend = '0;
        cin    = 1'b0;
        unique case (dig_o)
            DG_POS: begin
                addend = (op_i == OP_SQRT) ? ~(q_w | ebit) : ~dvs_i;
                cin    = 1'b1;
            end
            DG_NEG: begin
                addend = (op_i == OP_SQRT) ? (qm_w | ebit | (ebit << 1)) : dvs_i;
            end
            default: begin
                addend = '0;
            end
        endcase
    end

    // 3:2 carry-save step, no carry propagation
    assign nsum = sh_s ^ sh_c ^ addend;
    assign maj  = (sh_s[WW-2:0] & sh_c[WW-2:0]) |
                  (sh_s[WW-2:0] & addend[WW-2:0]) |
                  (sh_c[WW-2:0] & addend[WW-2:0]);
    assign ncar = {maj, cin};

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ws_q <= '0;
            wc_q <= '0;
        end else if (load_i) begin
            ws_q <= init_i;
            wc_q <= '0;
        end else if (step_i) begin
            ws_q <= nsum;
            wc_q <= ncar;
        end
    end

    assign rem_w = ws_q + wc_q;
    assign neg_o = rem_w[WW-1];

    AST_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i || step_i) |=> ($signed(rem_w) >= -LIM && $signed(rem_w) < LIM)); // R9

endmodule

// File: rtl/dsq_otf.sv
module dsq_otf
    import dsq_pkg::*;
#(
    parameter int QW = 26,
    parameter int CW = 5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  dsq_op_e       op_i,
    input  logic          step_i,
    input  dsq_digit_e    dig_i,
    input  logic [CW-1:0] idx_i,
    output logic [QW-1:0] q_o,
    output logic [QW-1:0] qm_o
);

    localparam logic [QW-1:0] ONE  = {{(QW-1){1'b0}}, 1'b1};
    localparam logic [QW-1:0] UNIT = ONE << (QW - 1);
    localparam logic [CW-1:0] PTOP = CW'(QW - 2);
    localparam logic [CW-1:0] GTOP = CW'(QW - 1);

    logic [QW-1:0] q_q, qm_q, dbit;

    assign dbit = ONE << (PTOP - idx_i);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q_q  <= '0;
            qm_q <= '0;
        end else if (load_i) begin
            // root starts at 1.0, quotient at 0; second register is one unit below
            q_q  <= (op_i == OP_SQRT) ? UNIT : '0;
            qm_q <= (op_i == OP_SQRT) ? '0 : UNIT;
        end else if (step_i) begin
            unique case (dig_i)
                DG_POS: begin
                    q_q  <= q_q | dbit;
                    qm_q <= q_q;
                end
                DG_NEG: begin
                    q_q  <= qm_q | dbit;
                    qm_q <= qm_q;
                end
                default: begin
                    q_q  <= q_q;
                    qm_q <= qm_q | dbit;
                end
            endcase
        end
    end

    assign q_o  = q_q;
    assign qm_o = qm_q;

    AST_OTF_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i |-> ((q_q - qm_q) == (ONE << (GTOP - idx_i)))); // R4

endmodule

// File: rtl/dsq_unit.sv
module dsq_unit
    import dsq_pkg::*;
#(
    parameter int MW = 24
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic          op_sqrt_i,
    input  logic [MW-1:0] opa_i,
    input  logic [MW-1:0] opb_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [MW:0]   res_o
);

    localparam int NDIG = MW + 1;
    localparam int QW   = MW + 2;
    localparam int FB   = MW + 2;
    localparam int WW   = FB + 4;
    localparam int CW   = $clog2(NDIG + 1);
    localparam int LAT  = NDIG + 3;
    localparam int LCW  = $clog2(LAT + 2);
    localparam logic [CW-1:0] LAST = CW'(NDIG - 1);
    localparam logic [WW-1:0] HALF = {{(WW-1){1'b0}}, 1'b1} << (FB - 1);

    dsq_state_e    state_q, state_d;
    dsq_op_e       op_q, op_in;
    dsq_digit_e    dig;
    logic [WW-1:0] dvs_q, dvs_d, init_d, a_w;
    logic [CW-1:0] cnt_q;
    logic [QW-1:0] q_r, qm_r, sel_w;
    logic          neg_q, rem_neg, accept, step;
    logic [MW:0]   res_q;
    logic [LCW-1:0] lat_q;

    assign op_in  = op_sqrt_i ? OP_SQRT : OP_DIV;
    assign accept = (state_q == ST_IDLE) && start_i;
    assign step   = (state_q == ST_ITER);

    // operand alignment: dividend halved, radicand biased by the initial root 1.0
    assign a_w    = {{(WW-MW){1'b0}}, opa_i} << 1;
    assign init_d = op_sqrt_i ? (a_w - HALF) : a_w;
    assign dvs_d  = {{(WW-MW){1'b0}}, opb_i} << 2;

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_ITER;
            ST_ITER: if (cnt_q == LAST) state_d = ST_SIGN;
            ST_SIGN: state_d = ST_CORR;
            ST_CORR: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o = (state_q != ST_IDLE);
        done_o = (state_q == ST_DONE);
        res_o  = res_q;
    end

    // datapath control registers
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            op_q  <= OP_DIV;
            dvs_q <= '0;
            cnt_q <= '0;
            neg_q <= 1'b0;
            res_q <= '0;
        end else begin
            if (accept) begin
                op_q  <= op_in;
                dvs_q <= dvs_d;
                cnt_q <= '0;
            end else if (step) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == ST_SIGN) begin
                neg_q <= rem_neg;
            end
            if (state_q == ST_CORR) begin
                res_q <= sel_w[MW:0];
            end
        end
    end

    assign sel_w = neg_q ? qm_r : q_r;

    dsq_recur #(.WW(WW), .FB(FB), .QW(QW), .CW(CW)) u_rec (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (accept),
        .step_i (step),
        .op_i   (op_q),
        .init_i (init_d),
        .dvs_i  (dvs_q),
        .q_i    (q_r),
        .qm_i   (qm_r),
        .idx_i  (cnt_q),
        .dig_o  (dig),
        .neg_o  (rem_neg)
    );

    dsq_otf #(.QW(QW), .CW(CW)) u_otf (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (accept),
        .op_i   (op_in),
        .step_i (step),
        .dig_i  (dig),
        .idx_i  (cnt_q),
        .q_o    (q_r),
        .qm_o   (qm_r)
    );

    // cycle counter for the latency property
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lat_q <= '0;
        end else if (accept) begin
            lat_q <= LCW'(1);
        end else if (busy_o && lat_q < LCW'(LAT + 1)) begin
            lat_q <= lat_q + 1'b1;
        end
    end

    AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (lat_q == LCW'(LAT))); // R3
    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R3
    AST_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> busy_o); // R2
    AST_CAPTURE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> ($stable(op_q) && $stable(dvs_q))); // R7
    AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o || done_o) |=> $stable(res_o)); // R8
    AST_RES_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_CORR) |-> !sel_w[QW-1]); // R5

endmodule

// File: tb/sim_dsq_unit.sv
module sim_dsq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_sqrt = 1'b0;
    logic [23:0] opa = '0;
    logic [23:0] opb = '0;
    logic        busy, done;
    logic [24:0] res;

    always #2ns clk = ~clk;

    dsq_unit u0 (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .start_i   (start),
        .op_sqrt_i (op_sqrt),
        .opa_i     (opa),
        .opb_i     (opb),
        .busy_o    (busy),
        .done_o    (done),
        .res_o     (res)
    );

    typedef struct {
        logic [24:0] val;
        int          st;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   n_done = 0;
    bit   finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [24:0] ref_div(input logic [23:0] a, input logic [23:0] b);
        longint unsigned num;
        num = longint'(a) << 24;
        return 25'(num / longint'(b));
    endfunction

    function automatic logic [24:0] ref_sqrt(input logic [23:0] a);
        longint unsigned v, r, t;
        v = longint'(a) << 26;
        r = 0;
        for (int k = 25; k >= 0; k--) begin
            t = r | (longint'(1) << k);
            if (t * t <= v) r = t;
        end
        return 25'(r);
    endfunction

    // monitor: pops the scoreboard when a completion pulse is seen
    always @(negedge clk) begin
        if (rst_n && done) begin
            n_done++;
            if (sb.size() == 0) begin
                chk(1'b0, "R7 done with empty scoreboard", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(res == e.val, e.tag, res, e.val);
                chk((cyc - e.st) == 28, "R3 latency", cyc - e.st, 28);
            end
        end
    end

    task automatic run_op(input bit sq, input logic [23:0] a, input logic [23:0] b, input string tag);
        logic [24:0] prev;
        exp_t e;
        prev = res;
        @(negedge clk);
        op_sqrt = sq;
        opa = a;
        opb = b;
        start = 1'b1;
        e.val = sq ? ref_sqrt(a) : ref_div(a, b);
        e.st = cyc;
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
        // R6: scramble inputs after capture
        opa = ~a;
        opb = ~b;
        op_sqrt = ~sq;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        repeat (3) @(negedge clk);
        chk(res == prev, "R8 result held while running", res, prev);
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R3 done single cycle", done, 0);
        chk(busy == 1'b0, "R2 idle after done", busy, 0);
    endtask

    initial begin
        logic [31:0] lf;
        logic [24:0] held;
        exp_t e;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && res == '0, "R1 reset values", {busy, done, res}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && res == '0, "R1 after release", {busy, done, res}, 0);

        // division
        run_op(1'b0, 24'h800000, 24'h800000, "R4 div equal operands");
        run_op(1'b0, 24'hC00000, 24'h800000, "R10 div exact 1.5");
        run_op(1'b0, 24'h800000, 24'hFFFFFF, "R9 div smallest quotient");
        run_op(1'b0, 24'hFFFFFF, 24'h800000, "R9 div largest quotient");
        run_op(1'b0, 24'hABCDEF, 24'h9A3B21, "R4 div mixed");
        run_op(1'b0, 24'h9E3779, 24'hB504F3, "R10 div inexact");

        // square root
        run_op(1'b1, 24'h800000, 24'h000000, "R9 sqrt smallest radicand");
        run_op(1'b1, 24'hFFFFFF, 24'h000000, "R9 sqrt largest radicand");
        run_op(1'b1, 24'h900000, 24'h000000, "R10 sqrt exact square");
        run_op(1'b1, 24'hC00000, 24'h000000, "R5 sqrt 1.5");
        run_op(1'b1, 24'hA12345, 24'h000000, "R10 sqrt inexact");

        // mixed pseudo-random operands
        lf = 32'h1B2C3D4E;
        for (int i = 0; i < 6; i++) begin
            lf = lf * 32'd1664525 + 32'd1013904223;
            run_op(1'b0, {1'b1, lf[22:0]}, {1'b1, lf[31:9]}, "R4 div sweep");
            run_op(1'b1, {1'b1, lf[30:8]}, 24'h000000, "R5 sqrt sweep");
        end

        // R8: idle, inputs wiggle without start
        held = res;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            opa = opa + 24'h12345;
            op_sqrt = ~op_sqrt;
        end
        chk(res == held, "R8 result stable while idle", res, held);

        // R7: start pulses while busy are ignored
        @(negedge clk);
        op_sqrt = 1'b0;
        opa = 24'hD00000;
        opb = 24'h900000;
        start = 1'b1;
        e.val = ref_div(24'hD00000, 24'h900000);
        e.st = cyc;
        e.tag = "R7 div with ignored restarts";
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        op_sqrt = 1'b1;
        opa = 24'hFFFFFF;
        opb = 24'h800000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R7 no restart after ignored start", busy, 0);
        repeat (40) @(negedge clk);
        chk(n_done == 24, "R7 completion count", n_done, 24);
        chk(sb.size() == 0, "R7 scoreboard drained", sb.size(), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R3 watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule